// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

This block gathers eight interrupt request lines, picks the most urgent pending and unmasked one, and raises a single interrupt output toward the processor. The processor answers with two acknowledge pulses. When the first pulse ends, the controller decides which line it is serving. It records that line as in service and clears its pending request. During the second pulse it presents an 8-bit vector built from a software base value and the line number.

A single configuration bit chooses how every line is detected. In edge mode a rising transition is latched as a request. In level mode a high level is itself the request. A line that has fallen by the time the first acknowledge pulse ends still gets a vector: the lowest-priority one, and no in-service bit is set. An interrupt routine can read the in-service register to tell this case apart from a real request on line 7. A four-address register port holds the mask, the detection mode, the vector base and the end-of-service command.

Top module: `prio_intc`

## Requirements
- R1: After reset, int_out is 0, and the mask, mode, base and in-service registers all read 0.
- R2: In edge mode (mode bit0 = 0), a 0-to-1 transition on a line latches a request. A line that is held high after it has been served and cleared does not request again until it falls and rises once more.
- R3: In level mode (mode bit0 = 1), a high line is a pending request. If the line is still high when its in-service bit is cleared, int_out rises again.
- R4: Line 0 has the highest priority and line 7 the lowest. When several lines are pending, the vector names the lowest-numbered one.
- R5: int_out is 1 only when the most urgent pending request outranks the most urgent in-service line. A more urgent line can therefore interrupt a less urgent one that is being served.
- R6: A line whose mask bit is 1 never causes int_out. Once the bit is cleared, the held request is forwarded.
- R7: When the first acknowledge pulse falls, the winning line's in-service bit is set and its request is cleared. While the second pulse is held, vec_valid is 1 and vec_out = {base[7:3], line[2:0]}.
- R8: If no unmasked line is still high when the first pulse falls, vec_out = {base[7:3], 3'b111} and the in-service register does not change.
- R9: A write to address 3 with bit3 = 0 clears the most urgent in-service bit. With bit3 = 1 it clears the in-service bit selected by bits[2:0].
- R10: Register map: address 0 is the mask (bit n = line n), address 1 is the mode (bit0 only), address 2 is the base (bits 7:3 kept, bits 2:0 read 0), and a read of address 3 returns the in-service register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Interrupt request lines, bit n = line n |
| int_out | output | 1 | Interrupt request to the processor |
| ack_in | input | 1 | Acknowledge, active high, two pulses per handshake |
| vec_out | output | 8 | Vector number |
| vec_valid | output | 1 | High while the second acknowledge pulse is in progress |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |

## Verification
The assertions assume that the acknowledge input only ever forms complete two-pulse sequences, and that each pulse and each gap lasts at least one clock. They also assume that request lines are already synchronous to clk. The bench keeps every acknowledge pulse and gap exactly one clock long and changes lines and register strobes only on falling clock edges. It issues end-of-service commands only outside an acknowledge sequence, so an in-service bit is never set and cleared in the same cycle.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int N_LINES = 8;
    localparam int IDX_W   = $clog2(N_LINES);
    localparam int VEC_W   = 8;
    localparam int BASE_W  = VEC_W - IDX_W;

    typedef logic [N_LINES-1:0] line_vec_t;
    typedef logic [IDX_W-1:0]   line_idx_t;

    typedef enum logic [1:0] {
        ACK_IDLE   = 2'd0,
        ACK_FIRST  = 2'd1,
        ACK_GAP    = 2'd2,
        ACK_SECOND = 2'd3
    } ack_state_t;

    typedef struct packed {
        logic      found;
        line_idx_t idx;
    } pick_t;

    // most urgent set bit: the lowest index wins
    function automatic pick_t lowest_set(input line_vec_t v);
        pick_t p;
        p.found = 1'b0;
        p.idx   = '0;
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.found = 1'b1;
                p.idx   = line_idx_t'(i);
            end
        end
        return p;
    endfunction

    function automatic line_vec_t onehot_of(input line_idx_t i);
        line_vec_t r;
        r    = '0;
        r[i] = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/pic_req_capture.sv
module pic_req_capture
    import pic_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      level_mode,
    input  line_vec_t irq_in,
    input  line_vec_t clr,
    output line_vec_t irr
);
    line_vec_t irq_q;
    line_vec_t irr_q;
    line_vec_t rise;

    assign rise = irq_in & ~irq_q;
    assign irr  = irr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= '0;
            irr_q <= '0;
        end else begin
            irq_q <= irq_in;
            if (level_mode) irr_q <= irq_in;
            else            irr_q <= (irr_q | rise) & ~clr;
        end
    end

    // R3: in level mode the request register tracks the lines
    p_level_follow_r3: assert property (@(posedge clk) disable iff (rst)
        level_mode |=> (irr_q == $past(irq_in)));

    // R2: a latched edge request only goes away through a clear
    p_edge_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!level_mode && clr == '0) |=> ((irr_q & $past(irr_q)) == $past(irr_q)));
endmodule

// File: rtl/pic_prio_resolve.sv
module pic_prio_resolve
    import pic_pkg::*;
(
    input  line_vec_t cand,
    input  line_vec_t isr,
    output logic      ok,
    output line_idx_t idx
);
    pick_t req_p;
    pick_t isr_p;

    always_comb begin
        req_p = lowest_set(cand);
        isr_p = lowest_set(isr);
        idx   = req_p.idx;
        ok    = req_p.found && (!isr_p.found || (req_p.idx < isr_p.idx));
    end
endmodule

// File: rtl/pic_ack_fsm.sv
module pic_ack_fsm
    import pic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ack_in,
    input  logic              win_ok,
    input  line_idx_t         win_idx,
    input  logic [BASE_W-1:0] base,
    output logic              sample,
    output logic              busy,
    output logic [VEC_W-1:0]  vec,
    output logic              vec_valid
);
    ack_state_t       state_q;
    ack_state_t       state_d;
    logic [VEC_W-1:0] vec_q;

    always_comb begin
        state_d = state_q;
        sample  = 1'b0;
        unique case (state_q)
            ACK_IDLE:   if (ack_in) state_d = ACK_FIRST;
            ACK_FIRST:  if (!ack_in) begin
                            state_d = ACK_GAP;
                            sample  = 1'b1;
                        end
            ACK_GAP:    if (ack_in) state_d = ACK_SECOND;
            ACK_SECOND: if (!ack_in) state_d = ACK_IDLE;
            default:    state_d = ACK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ACK_IDLE;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            if (sample) vec_q <= win_ok ? {base, win_idx} : {base, {IDX_W{1'b1}}};
        end
    end

    assign busy      = (state_q != ACK_IDLE);
    assign vec       = vec_q;
    assign vec_valid = (state_q == ACK_SECOND);

    // R7: the vector cannot change while it is presented
    p_vec_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ACK_SECOND) |-> $stable(vec_q));
endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import pic_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [N_LINES-1:0]  irq_in,
    output logic                int_out,
    input  logic                ack_in,
    output logic [VEC_W-1:0]    vec_out,
    output logic                vec_valid,
    input  logic                reg_wr,
    input  logic [1:0]          reg_addr,
    input  logic [7:0]          reg_wdata,
    output logic [7:0]          reg_rdata
);
    localparam logic [1:0] A_MASK = 2'd0;
    localparam logic [1:0] A_MODE = 2'd1;
    localparam logic [1:0] A_BASE = 2'd2;
    localparam logic [1:0] A_EOI  = 2'd3;

    line_vec_t         mask_q;
    logic              level_q;
    logic [BASE_W-1:0] base_q;
    line_vec_t         isr_q;

    line_vec_t irr;
    line_vec_t clr;
    logic      sample;
    logic      busy;
    logic      int_ok;
    line_idx_t int_idx;
    logic      smp_ok;
    line_idx_t smp_idx;
    logic      eoi_wr;
    line_vec_t eoi_clr;
    pick_t     isr_top;

    pic_req_capture u_cap (
        .clk        (clk),
        .rst        (rst),
        .level_mode (level_q),
        .irq_in     (irq_in),
        .clr        (clr),
        .irr        (irr)
    );

    // the request to forward, from latched requests
    pic_prio_resolve u_int_res (
        .cand (irr & ~mask_q),
        .isr  (isr_q),
        .ok   (int_ok),
        .idx  (int_idx)
    );

    // the request that is still valid when the first pulse falls
    pic_prio_resolve u_smp_res (
        .cand (irr & irq_in & ~mask_q),
        .isr  (isr_q),
        .ok   (smp_ok),
        .idx  (smp_idx)
    );

    pic_ack_fsm u_ack (
        .clk       (clk),
        .rst       (rst),
        .ack_in    (ack_in),
        .win_ok    (smp_ok),
        .win_idx   (smp_idx),
        .base      (base_q),
        .sample    (sample),
        .busy      (busy),
        .vec       (vec_out),
        .vec_valid (vec_valid)
    );

    assign int_out = int_ok && !busy;

    always_comb begin
        clr = '0;
        if (sample) begin
            clr = irr & ~irq_in;
            if (smp_ok) clr = clr | onehot_of(smp_idx);
        end
    end

    assign eoi_wr  = reg_wr && (reg_addr == A_EOI);
    assign isr_top = lowest_set(isr_q);

    always_comb begin
        eoi_clr = '0;
        if (eoi_wr) begin
            if (reg_wdata[3])       eoi_clr = onehot_of(reg_wdata[IDX_W-1:0]);
            else if (isr_top.found) eoi_clr = onehot_of(isr_top.idx);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '0;
            level_q <= 1'b0;
            base_q  <= '0;
            isr_q   <= '0;
        end else begin
            if (reg_wr && reg_addr == A_MASK) mask_q  <= reg_wdata;
            if (reg_wr && reg_addr == A_MODE) level_q <= reg_wdata[0];
            if (reg_wr && reg_addr == A_BASE) base_q  <= reg_wdata[7:IDX_W];
            isr_q <= (isr_q & ~eoi_clr) | ((sample && smp_ok) ? onehot_of(smp_idx) : '0);
        end
    end

    always_comb begin
        unique case (reg_addr)
            A_MASK:  reg_rdata = mask_q;
            A_MODE:  reg_rdata = {7'd0, level_q};
            A_BASE:  reg_rdata = {base_q, {IDX_W{1'b0}}};
            default: reg_rdata = isr_q;
        endcase
    end

    // R6: a forwarded request is latched and unmasked
    p_int_unmasked_r6: assert property (@(posedge clk) disable iff (rst)
        int_out |-> (!mask_q[int_idx] && irr[int_idx]));

    // R7: a valid sample adds exactly one in-service bit
    p_isr_grow_r7: assert property (@(posedge clk) disable iff (rst)
        (sample && smp_ok && !eoi_wr) |=> ($countones(isr_q) == $countones($past(isr_q)) + 1));

    // R8: a spurious sample leaves the in-service register alone
    p_spur_keep_r8: assert property (@(posedge clk) disable iff (rst)
        (sample && !smp_ok && !eoi_wr) |=> $stable(isr_q));

    // R9: a non-specific end of service removes one bit
    p_eoi_drop_r9: assert property (@(posedge clk) disable iff (rst)
        (eoi_wr && !reg_wdata[3] && !sample && (isr_q != '0))
        |=> ($countones(isr_q) == $countones($past(isr_q)) - 1));
endmodule

// File: tb/prio_intc_tb_top.sv
module prio_intc_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] irq_in;
    logic       int_out;
    logic       ack_in;
    logic [7:0] vec_out;
    logic       vec_valid;
    logic       reg_wr;
    logic [1:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    prio_intc dut_i (
        .clk(clk), .rst(rst), .irq_in(irq_in), .int_out(int_out),
        .ack_in(ack_in), .vec_out(vec_out), .vec_valid(vec_valid),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 2'd0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
        reg_addr = 2'd0;
    endtask

    task automatic set_irq(input logic [7:0] v);
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
    endtask

    // two acknowledge pulses; drop clears lines during the first pulse
    task automatic ack_seq(input logic [7:0] drop, output logic [7:0] v, output logic vv);
        @(negedge clk); ack_in = 1'b1;
        @(negedge clk); ack_in = 1'b0; irq_in = irq_in & ~drop;
        @(negedge clk); ack_in = 1'b1;
        @(negedge clk); v = vec_out; vv = vec_valid; ack_in = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 int_out", int_out, 0);
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], d);
            check("R1 reg reset", d, 0);
        end
    endtask

    task automatic t_regs();
        logic [7:0] d;
        wr(2'd2, 8'hFF); rd(2'd2, d); check("R10 base bits", d, 8'hF8);
        wr(2'd1, 8'hFE); rd(2'd1, d); check("R10 mode bit0 only", d, 8'h00);
        wr(2'd0, 8'hA5); rd(2'd0, d); check("R10 mask", d, 8'hA5);
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h40);
    endtask

    task automatic t_edge();
        logic [7:0] v, d; logic vv;
        set_irq(8'h04);
        check("R2 edge raises int", int_out, 1);
        ack_seq(8'h00, v, vv);
        check("R7 vec_valid", vv, 1);
        check("R7 vector line2", v, 8'h42);
        rd(2'd3, d); check("R7 isr set", d, 8'h04);
        check("R7 request cleared", int_out, 0);
        wr(2'd3, 8'h00);
        rd(2'd3, d); check("R9 eoi clears", d, 8'h00);
        check("R2 held line no re-request", int_out, 0);
        set_irq(8'h00);
        set_irq(8'h04);
        check("R2 new edge requests", int_out, 1);
        ack_seq(8'h00, v, vv);
        wr(2'd3, 8'h00);
        set_irq(8'h00);
    endtask

    task automatic t_level();
        logic [7:0] v, d; logic vv;
        wr(2'd1, 8'h01);
        set_irq(8'h10);
        check("R3 level raises int", int_out, 1);
        ack_seq(8'h00, v, vv);
        check("R3 vector line4", v, 8'h44);
        check("R3 blocked while served", int_out, 0);
        wr(2'd3, 8'h00);
        check("R3 re-request after eoi", int_out, 1);
        ack_seq(8'h00, v, vv);
        check("R3 second vector", v, 8'h44);
        set_irq(8'h00);
        wr(2'd3, 8'h00);
        rd(2'd3, d); check("R3 isr empty", d, 8'h00);
        check("R3 line low no int", int_out, 0);
        wr(2'd1, 8'h00);
    endtask

    task automatic t_priority();
        logic [7:0] v, d; logic vv;
        set_irq(8'h22);
        ack_seq(8'h00, v, vv);
        check("R4 lowest index wins", v, 8'h41);
        check("R5 line5 blocked by isr1", int_out, 0);
        set_irq(8'h23);
        check("R5 line0 nests", int_out, 1);
        ack_seq(8'h00, v, vv);
        check("R5 nested vector", v, 8'h40);
        rd(2'd3, d); check("R5 two in service", d, 8'h03);
        wr(2'd3, 8'h00);
        rd(2'd3, d); check("R9 nonspecific clears top", d, 8'h02);
        check("R5 still blocked", int_out, 0);
        wr(2'd3, 8'h09);
        rd(2'd3, d); check("R9 specific clears line1", d, 8'h00);
        check("R5 line5 forwarded", int_out, 1);
        ack_seq(8'h00, v, vv);
        check("R4 line5 vector", v, 8'h45);
        wr(2'd3, 8'h00);
        set_irq(8'h00);
    endtask

    task automatic t_mask();
        logic [7:0] v; logic vv;
        wr(2'd0, 8'h08);
        set_irq(8'h08);
        check("R6 masked no int", int_out, 0);
        wr(2'd0, 8'h00);
        check("R6 unmask forwards", int_out, 1);
        ack_seq(8'h00, v, vv);
        check("R6 vector line3", v, 8'h43);
        wr(2'd3, 8'h00);
        set_irq(8'h00);
    endtask

    task automatic t_spurious();
        logic [7:0] v, d; logic vv;
        set_irq(8'h40);
        check("R8 int before drop", int_out, 1);
        ack_seq(8'h40, v, vv);
        check("R8 spurious vector", v, 8'h47);
        rd(2'd3, d); check("R8 isr untouched", d, 8'h00);
        check("R8 no int afterwards", int_out, 0);
        set_irq(8'h80);
        ack_seq(8'h00, v, vv);
        check("R8 real line7 vector", v, 8'h47);
        rd(2'd3, d); check("R8 real line7 isr", d, 8'h80);
        wr(2'd3, 8'h00);
        set_irq(8'h00);
    endtask

    initial begin
        rst = 1'b1; irq_in = '0; ack_in = 1'b0;
        reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_edge();
        t_level();
        t_priority();
        t_mask();
        t_spurious();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule